// File: doc/BRIEF.md
# Subroutine Call Micro-Step Sequencer

This block carries out a subroutine call as six fixed single-cycle micro-steps. A small datapath holds a program counter, a stack pointer, a memory address latch, a memory buffer, an ALU operand latch and an ALU result latch. Two internal buses link them, and one bus may load two registers in the same cycle. The block first reads the call target from memory at the current program counter. It then writes the return address (program counter plus one) at the current stack top, and finally lowers the stack pointer by one through the same ALU.

A one-cycle `start` pulse, sampled while the sequencer is idle, begins a call. `done` is high during the sixth step. A `start` held high in that step begins the next call at once, with no idle cycle between the two. The memory port assumes a single-cycle memory: `mem_rdata` must be valid in the same cycle that `mem_rd_n` is low. The port has no handshake and no back-pressure, so the sequence never stalls.

Top module: `call_seq`

## Requirements
- R1: While `rst` is sampled high, and on the first cycle after it, `pc_out`, `mem_addr` and `mem_wdata` are 0, `sp_out` equals the `STACK_TOP` parameter, `mem_rd_n` and `mem_wr_n` are 1 and `done` is 0.
- R2: The block stays idle, with both strobes high and `done` low, until `start` is sampled high. A `start` sampled while a call is in progress (steps one to five) has no effect.
- R3: In the second cycle after `start` is sampled, `mem_rd_n` is 0 and `mem_addr` equals the program counter from before the call. The word read in that cycle appears on `pc_out` from the end of the third cycle onward.
- R4: In the fifth cycle, `mem_wr_n` is 0, `mem_addr` equals the stack pointer from before the call, and `mem_wdata` equals the old program counter plus one, modulo 2^16.
- R5: `mem_rd_n` and `mem_wr_n` are never both 0. Both are 1 in the first, third, fourth and sixth cycles.
- R6: `done` is 1 for exactly the sixth cycle. A `start` sampled in that cycle begins a new call whose first cycle follows immediately.
- R7: After `done`, `sp_out` equals the old stack pointer minus one, modulo 2^16, so 0 wraps to 16'hFFFF.
- R8: A call made from program counter 16'hFFFF stores a return address of 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a call when sampled high while idle or in the last step |
| mem_rdata | input | 16 | Memory read data, valid while `mem_rd_n` is low |
| done | output | 1 | High during the final step of a call |
| mem_addr | output | 16 | Memory address, driven from the address latch |
| mem_wdata | output | 16 | Memory write data, driven from the memory buffer |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| pc_out | output | 16 | Current program counter |
| sp_out | output | 16 | Current stack pointer |

## Verification
A wrong step state shows within one cycle as a strobe in the wrong cycle, or as a missing or repeated `done`. A wrongly loaded address latch or buffer shows on the address and data lines in the second or fifth cycle of the same call. A bad ALU result shows as a wrong return word in cycle five, or as a wrong `sp_out` on the cycle after `done`. A wrong target transfer shows on `pc_out` before the call ends, and the next call's read address repeats it. The wrap cases for the stack pointer and the return address are driven on purpose, because an error in the carry there leaves every other call correct.

// File: rtl/call_seq_pkg.sv
package call_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_1    = 3'd1,
    ST_2    = 3'd2,
    ST_3    = 3'd3,
    ST_4    = 3'd4,
    ST_5    = 3'd5,
    ST_6    = 3'd6
  } step_t;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_PC   = 3'd1,
    SRC_SP   = 3'd2,
    SRC_MBR  = 3'd3,
    SRC_Z    = 3'd4
  } src_t;

  // ALU function code {f2,f1,f0}: f0 high selects increment, f2 low selects decrement
  typedef enum logic [2:0] {
    FN_DEC  = 3'b000,
    FN_PASS = 3'b100,
    FN_INC  = 3'b101
  } alu_fn_t;

  typedef struct packed {
    src_t    bus_b;
    src_t    bus_c;
    logic    ld_pc;      // from bus B
    logic    ld_sp;      // from bus C
    logic    ld_mar;     // from bus C
    logic    ld_mbr_bus; // from bus C
    logic    ld_mbr_mem; // from memory read data
    logic    ld_y;       // from bus C
    logic    ld_z;       // from ALU result
    logic    alu_flow;   // ALU operand taken from bus C instead of Y
    alu_fn_t fn;
    logic    mem_rd;
    logic    mem_wr;
  } ctrl_t;

endpackage

// File: rtl/call_seq_step.sv
module call_seq_step
  import call_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  output step_t step,
  output logic  done
);

  step_t step_q;
  step_t step_d;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE: if (start) step_d = ST_1;
      ST_1:    step_d = ST_2;
      ST_2:    step_d = ST_3;
      ST_3:    step_d = ST_4;
      ST_4:    step_d = ST_5;
      ST_5:    step_d = ST_6;
      ST_6:    step_d = start ? ST_1 : ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_IDLE;
    else     step_q <= step_d;
  end

  assign step = step_q;
  assign done = (step_q == ST_6);

endmodule

// File: rtl/call_seq_decode.sv
module call_seq_decode
  import call_seq_pkg::*;
(
  input  step_t step,
  output ctrl_t cw
);

  always_comb begin
    cw = '0;
    cw.bus_b = SRC_NONE;
    cw.bus_c = SRC_NONE;
    cw.fn    = FN_PASS;
    unique case (step)
      ST_1: begin
        // program counter fans out to address latch and ALU operand latch
        cw.bus_c  = SRC_PC;
        cw.ld_mar = 1'b1;
        cw.ld_y   = 1'b1;
      end
      ST_2: begin
        // fetch target; return address computed in parallel
        cw.mem_rd     = 1'b1;
        cw.ld_mbr_mem = 1'b1;
        cw.fn         = FN_INC;
        cw.ld_z       = 1'b1;
      end
      ST_3: begin
        cw.bus_b  = SRC_MBR;
        cw.ld_pc  = 1'b1;
        cw.bus_c  = SRC_SP;
        cw.ld_mar = 1'b1;
      end
      ST_4: begin
        cw.bus_c      = SRC_Z;
        cw.ld_mbr_bus = 1'b1;
      end
      ST_5: begin
        // store return address; stack pointer decremented in parallel
        cw.mem_wr   = 1'b1;
        cw.bus_c    = SRC_SP;
        cw.ld_y     = 1'b1;
        cw.alu_flow = 1'b1;
        cw.fn       = FN_DEC;
        cw.ld_z     = 1'b1;
      end
      ST_6: begin
        cw.bus_c = SRC_Z;
        cw.ld_sp = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/call_seq_alu.sv
module call_seq_alu
  import call_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  alu_fn_t      fn,
  output logic [W-1:0] y
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (fn)
      FN_INC:  y = a + ONE;
      FN_DEC:  y = a - ONE;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/call_seq_path.sv
module call_seq_path
  import call_seq_pkg::*;
#(
  parameter int             W         = 16,
  parameter logic [W-1:0]   STACK_TOP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrl_t        cw,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] pc,
  output logic [W-1:0] sp,
  output logic [W-1:0] mar,
  output logic [W-1:0] mbr
);

  logic [W-1:0] y_q, z_q;
  logic [W-1:0] bus_b, bus_c;
  logic [W-1:0] alu_a, alu_y;

  function automatic logic [W-1:0] pick(input src_t s, input logic [W-1:0] p,
                                        input logic [W-1:0] k, input logic [W-1:0] m,
                                        input logic [W-1:0] z);
    unique case (s)
      SRC_PC:  pick = p;
      SRC_SP:  pick = k;
      SRC_MBR: pick = m;
      SRC_Z:   pick = z;
      default: pick = '0;
    endcase
  endfunction

  assign bus_b = pick(cw.bus_b, pc, sp, mbr, z_q);
  assign bus_c = pick(cw.bus_c, pc, sp, mbr, z_q);
  assign alu_a = cw.alu_flow ? bus_c : y_q;

  call_seq_alu #(.W(W)) u_alu (
    .a  (alu_a),
    .fn (cw.fn),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      sp  <= STACK_TOP;
      mar <= '0;
      mbr <= '0;
      y_q <= '0;
      z_q <= '0;
    end else begin
      if (cw.ld_pc)      pc  <= bus_b;
      if (cw.ld_sp)      sp  <= bus_c;
      if (cw.ld_mar)     mar <= bus_c;
      if (cw.ld_mbr_mem) mbr <= mem_rdata;
      else if (cw.ld_mbr_bus) mbr <= bus_c;
      if (cw.ld_y)       y_q <= bus_c;
      if (cw.ld_z)       z_q <= alu_y;
    end
  end

endmodule

// File: rtl/call_seq.sv
module call_seq
  import call_seq_pkg::*;
#(
  parameter int           W         = 16,
  parameter logic [W-1:0] STACK_TOP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] mem_rdata,
  output logic         done,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_rd_n,
  output logic         mem_wr_n,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] sp_out
);

  step_t step;
  ctrl_t cw;

  call_seq_step u_step (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .step  (step),
    .done  (done)
  );

  call_seq_decode u_dec (
    .step (step),
    .cw   (cw)
  );

  call_seq_path #(.W(W), .STACK_TOP(STACK_TOP)) u_path (
    .clk       (clk),
    .rst       (rst),
    .cw        (cw),
    .mem_rdata (mem_rdata),
    .pc        (pc_out),
    .sp        (sp_out),
    .mar       (mem_addr),
    .mbr       (mem_wdata)
  );

  assign mem_rd_n = ~cw.mem_rd;
  assign mem_wr_n = ~cw.mem_wr;

endmodule

// File: rtl/call_seq_chk.sv
module call_seq_chk #(
  parameter int           W         = 16,
  parameter logic [W-1:0] STACK_TOP = '1
) (
  input logic         clk,
  input logic         rst,
  input logic         done,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_rdata,
  input logic         mem_rd_n,
  input logic         mem_wr_n,
  input logic [W-1:0] pc_out,
  input logic [W-1:0] sp_out
);

  AST_RESET_SP: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sp_out == STACK_TOP && mem_rd_n && mem_wr_n && !done)); // R1

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_rd_n && !mem_wr_n)); // R5

  AST_READ_AT_PC: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |-> (mem_addr == pc_out)); // R3

  AST_TARGET_TO_PC: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |=> ##1 (pc_out == $past(mem_rdata, 2))); // R3

  AST_WRITE_AT_SP: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_n |-> (mem_addr == sp_out)); // R4

  AST_WRITE_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_n |=> done); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_SP_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    done |=> (sp_out == $past(sp_out) - 1'b1)); // R7

endmodule

bind call_seq call_seq_chk #(.W(W), .STACK_TOP(STACK_TOP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata),
  .mem_rd_n  (mem_rd_n),
  .mem_wr_n  (mem_wr_n),
  .pc_out    (pc_out),
  .sp_out    (sp_out)
);

// File: tb/call_seq_tb.sv
`timescale 1ns/100ps
module call_seq_tb;

  localparam logic [15:0] TOP = 16'h0002;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] mem_rdata;
  logic        done, mem_rd_n, mem_wr_n;
  logic [15:0] mem_addr, mem_wdata, pc_out, sp_out;

  always #2.5 clk = ~clk;

  call_seq #(.W(16), .STACK_TOP(TOP)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mem_rdata(mem_rdata),
    .done(done), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .pc_out(pc_out), .sp_out(sp_out)
  );

  typedef struct packed {
    logic [15:0] rd_addr;
    logic [15:0] tgt;
    logic [15:0] wr_addr;
    logic [15:0] wr_data;
    logic [15:0] new_sp;
  } item_t;

  item_t       sb_q[$];
  item_t       cur;
  logic [15:0] rd_tgt = 16'h0;
  logic [15:0] m_pc = 16'h0;
  logic [15:0] m_sp = TOP;
  int          cyc = 0;
  bit          pend = 1'b0;
  int          total = 0;
  int          bad = 0;
  bit          ended = 1'b0;

  assign mem_rdata = rd_tgt;

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // bench view of the step position: 1..6 inside a call, 0 when idle
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else if (cyc == 0 || cyc == 6) cyc <= start ? 1 : 0;
    else cyc <= cyc + 1;
  end

  // driver: pushes the expected outcome and pulses start
  task automatic do_call(input logic [15:0] tgt);
    item_t it;
    @(negedge clk);
    while (cyc != 0 && cyc != 6) @(negedge clk);
    it.rd_addr = m_pc;
    it.tgt     = tgt;
    it.wr_addr = m_sp;
    it.wr_data = m_pc + 16'h1;
    it.new_sp  = m_sp - 16'h1;
    sb_q.push_back(it);
    m_pc   = tgt;
    m_sp   = m_sp - 16'h1;
    rd_tgt = tgt;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  // monitor: compares ports against the popped expectation
  always @(negedge clk) begin
    if (!rst && !ended) begin
      if (pend) begin
        chk(pc_out == cur.tgt, "R3 pc after call", pc_out, cur.tgt);
        chk(sp_out == cur.new_sp, "R7 sp after call", sp_out, cur.new_sp);
        pend = 1'b0;
      end
      chk(mem_rd_n == (cyc != 2), "R5 R2 read strobe", {15'h0, mem_rd_n}, {15'h0, cyc != 2});
      chk(mem_wr_n == (cyc != 5), "R5 R2 write strobe", {15'h0, mem_wr_n}, {15'h0, cyc != 5});
      chk(done == (cyc == 6), "R6 done", {15'h0, done}, {15'h0, cyc == 6});
      if (cyc == 1) begin
        if (sb_q.size() == 0) chk(1'b0, "R2 unexpected call", 16'h1, 16'h0);
        else cur = sb_q.pop_front();
      end
      if (cyc == 2)
        chk(mem_addr == cur.rd_addr, "R3 read address", mem_addr, cur.rd_addr);
      if (cyc == 5) begin
        chk(mem_addr == cur.wr_addr, "R4 write address", mem_addr, cur.wr_addr);
        chk(mem_wdata == cur.wr_data, "R4 R8 return word", mem_wdata, cur.wr_data);
      end
      if (cyc == 6) pend = 1'b1;
    end
  end

  task automatic finish_run();
    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 16'h0, 16'h0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    chk(pc_out == 16'h0, "R1 pc reset", pc_out, 16'h0);
    chk(sp_out == TOP, "R1 sp reset", sp_out, TOP);
    chk(mem_addr == 16'h0, "R1 addr reset", mem_addr, 16'h0);
    chk(mem_wdata == 16'h0, "R1 wdata reset", mem_wdata, 16'h0);
    chk(mem_rd_n && mem_wr_n && !done, "R1 strobes reset", {mem_rd_n, mem_wr_n, done}, 3'b110);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    do_call(16'h1234);            // pc 0 -> 1234, sp 2 -> 1
    do_call(16'hFFFF);            // back-to-back, R6; sp 1 -> 0
    repeat (3) @(negedge clk);
    do_call(16'h0040);            // R8 return word 0000, R7 sp 0 -> FFFF
    while (cyc != 3) @(negedge clk);
    start = 1'b1;                 // R2 stray start mid-call, must be ignored
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    do_call(16'h8000);
    do_call(16'hABCD);
    while (cyc != 0 || pend) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R2 scoreboard drained", 16'(sb_q.size()), 16'h0);
    chk(sp_out == 16'hFFFD, "R7 final sp", sp_out, 16'hFFFD);
    chk(pc_out == 16'hABCD, "R3 final pc", pc_out, 16'hABCD);
    finish_run();
  end

endmodule